// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block is the command state machine of a byte-wide parallel NOR flash. It sits behind the bus interface and sees each latched write cycle as an address and a data byte. It follows the unlock-prefixed command protocol and raises one-cycle requests toward the operation engine: byte program with its target address and data, chip erase, sector erase with a 4 KB sector index, block erase with a 64 KB block index, and entry to or exit from identification mode.

Every multi-cycle command opens with AAh at 555h and then 55h at 2AAh. The third cycle picks the path. A0h leads to program, 80h leads to the six-cycle erase path, 90h enters ID mode and F0h leaves it. A lone F0h at any address also leaves ID mode. Only the low 12 address bits take part in the unlock comparisons. While the engine reports busy, the decoder discards every write and restarts at idle. While ID mode is on, a small read mux returns the manufacturer code at offset 0 and the device code at offset 1.

Top module: `flash_cmd_decoder`

## Requirements
- R1: In the cycle after `rst` is sampled high, all request outputs are 0 and `id_mode` is 0, even if ID mode was on before.
- R2: The writes AAh@555h, 55h@2AAh, A0h@555h and then (A, D) make `prog_req` 1 in the cycle after the fourth write, with `prog_addr`=A and `prog_data`=D.
- R3: The writes AAh@555h, 55h@2AAh, 80h@555h, AAh@555h, 55h@2AAh and 10h@555h make `chip_erase_req` 1 in the cycle after the sixth write. 10h at any other low-12-bit address issues nothing.
- R4: The same five-cycle prefix followed by 30h at address A makes `sect_erase_req` 1, with `erase_sector` = A[ADDR_W-1:12].
- R5: The same five-cycle prefix followed by 50h at address A makes `blk_erase_req` 1, with `erase_block` = A[ADDR_W-1:16].
- R6: The writes AAh@555h, 55h@2AAh and 90h@555h pulse `id_enter_req` and set `id_mode` to 1 in the cycle after the third write.
- R7: Either AAh@555h, 55h@2AAh, F0h@555h, or a single F0h write at any address from idle, pulses `id_exit_req` and clears `id_mode`.
- R8: When `id_mode` is 1, `id_rd_data` is MFR_CODE if `id_rd_lsb`=0 and DEV_CODE if `id_rd_lsb`=1. When `id_mode` is 0, `id_rd_data` is 00h.
- R9: Address bits above bit 11 do not affect the unlock, command or chip-erase address comparisons.
- R10: A write whose address or data does not fit the current step sends the sequence back to idle and issues no request. Later writes that would have completed the old sequence issue nothing.
- R11: A write presented while `busy_i` is 1 is discarded, including a single-cycle F0h exit, and the sequence restarts at idle.
- R12: Each request is a single-cycle pulse, and at most one request is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | A latched write cycle is present |
| wr_addr | input | ADDR_W | Write cycle address |
| wr_data | input | 8 | Write cycle data byte |
| busy_i | input | 1 | Operation engine is running a program or erase |
| id_rd_lsb | input | 1 | Bit 0 of the read address, used in ID mode |
| prog_req | output | 1 | Byte program request pulse |
| prog_addr | output | ADDR_W | Program target address |
| prog_data | output | 8 | Program data byte |
| chip_erase_req | output | 1 | Chip erase request pulse |
| sect_erase_req | output | 1 | Sector erase request pulse |
| blk_erase_req | output | 1 | Block erase request pulse |
| erase_sector | output | ADDR_W-12 | Sector index for sector erase |
| erase_block | output | ADDR_W-16 | Block index for block erase |
| id_enter_req | output | 1 | ID mode entry pulse |
| id_exit_req | output | 1 | ID mode exit pulse |
| id_mode | output | 1 | ID mode is active |
| id_rd_data | output | 8 | Identification read data |

## Verification
A wrong sequence state has no output of its own. It shows only when a command completes: either a request that should not appear or a request that is missing. That happens one cycle after the last write of a sequence, so the bench checks the outputs after every single write. It does not only check at the end of a sequence. This catches both a request that never arrives and a request that fires early or after a broken sequence. A wrong ID-mode flag shows at once on the identification read data, which the bench checks at both offsets.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

    localparam int          CMP_BITS    = 12;
    localparam logic [11:0] ADR_KEY_A   = 12'h555;
    localparam logic [11:0] ADR_KEY_B   = 12'h2AA;

    localparam logic [7:0]  DAT_KEY_A   = 8'hAA;
    localparam logic [7:0]  DAT_KEY_B   = 8'h55;
    localparam logic [7:0]  DAT_PROG    = 8'hA0;
    localparam logic [7:0]  DAT_ERASE   = 8'h80;
    localparam logic [7:0]  DAT_ID_ON   = 8'h90;
    localparam logic [7:0]  DAT_ID_OFF  = 8'hF0;
    localparam logic [7:0]  DAT_CHIP    = 8'h10;
    localparam logic [7:0]  DAT_SECT    = 8'h30;
    localparam logic [7:0]  DAT_BLK     = 8'h50;

    localparam int          SECT_SHIFT  = 12;
    localparam int          BLK_SHIFT   = 16;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_KEY1,
        ST_PICK,
        ST_PROG,
        ST_EKEY1,
        ST_EKEY2,
        ST_ESEL
    } seq_state_t;

    typedef enum logic [2:0] {
        CMD_NONE,
        CMD_PROG,
        CMD_SECT,
        CMD_BLK,
        CMD_CHIP,
        CMD_ID_ON,
        CMD_ID_OFF
    } cmd_t;

    typedef struct packed {
        logic key_a;
        logic key_b;
        logic prog;
        logic erase;
        logic id_on;
        logic id_off3;
        logic off_any;
        logic chip;
        logic sect;
        logic blk;
    } cyc_class_t;

    function automatic logic pair_hit(input logic [11:0] a, input logic [7:0] d,
                                      input logic [11:0] ea, input logic [7:0] ed);
        return (a == ea) && (d == ed);
    endfunction

endpackage

// File: rtl/fcd_classify.sv
module fcd_classify
    import flash_cmd_pkg::*;
(
    input  logic [CMP_BITS-1:0] lo_addr,
    input  logic [7:0]          data,
    output cyc_class_t          cls
);
    always_comb begin
        cls         = '0;
        cls.key_a   = pair_hit(lo_addr, data, ADR_KEY_A, DAT_KEY_A);
        cls.key_b   = pair_hit(lo_addr, data, ADR_KEY_B, DAT_KEY_B);
        cls.prog    = pair_hit(lo_addr, data, ADR_KEY_A, DAT_PROG);
        cls.erase   = pair_hit(lo_addr, data, ADR_KEY_A, DAT_ERASE);
        cls.id_on   = pair_hit(lo_addr, data, ADR_KEY_A, DAT_ID_ON);
        cls.id_off3 = pair_hit(lo_addr, data, ADR_KEY_A, DAT_ID_OFF);
        cls.chip    = pair_hit(lo_addr, data, ADR_KEY_A, DAT_CHIP);
        cls.off_any = (data == DAT_ID_OFF);
        cls.sect    = (data == DAT_SECT);
        cls.blk     = (data == DAT_BLK);
    end
endmodule

// File: rtl/fcd_seq_fsm.sv
module fcd_seq_fsm
    import flash_cmd_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_valid,
    input  logic       busy_i,
    input  cyc_class_t cls,
    output cmd_t       cmd_fire
);
    seq_state_t state_q, state_d;

    always_comb begin
        state_d  = state_q;
        cmd_fire = CMD_NONE;
        if (wr_valid) begin
            if (busy_i) begin
                state_d = ST_IDLE;
            end else begin
                unique case (state_q)
                    ST_IDLE: begin
                        if (cls.key_a)        state_d  = ST_KEY1;
                        else if (cls.off_any) cmd_fire = CMD_ID_OFF;
                    end
                    ST_KEY1:  state_d = cls.key_b ? ST_PICK : ST_IDLE;
                    ST_PICK: begin
                        state_d = ST_IDLE;
                        if (cls.prog)         state_d  = ST_PROG;
                        else if (cls.erase)   state_d  = ST_EKEY1;
                        else if (cls.id_on)   cmd_fire = CMD_ID_ON;
                        else if (cls.id_off3) cmd_fire = CMD_ID_OFF;
                    end
                    ST_PROG: begin
                        state_d  = ST_IDLE;
                        cmd_fire = CMD_PROG;
                    end
                    ST_EKEY1: state_d = cls.key_a ? ST_EKEY2 : ST_IDLE;
                    ST_EKEY2: state_d = cls.key_b ? ST_ESEL  : ST_IDLE;
                    ST_ESEL: begin
                        state_d = ST_IDLE;
                        if (cls.chip)      cmd_fire = CMD_CHIP;
                        else if (cls.sect) cmd_fire = CMD_SECT;
                        else if (cls.blk)  cmd_fire = CMD_BLK;
                    end
                    default: state_d = ST_IDLE;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    // R11: a write taken while busy leaves the sequencer at idle
    assert_busy_restarts_R11: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && busy_i) |=> (state_q == ST_IDLE));

    // R10: a wrong second cycle never advances to the command step
    assert_key_mismatch_R10: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_KEY1 && wr_valid && !cls.key_b) |=> (state_q == ST_IDLE));
endmodule

// File: rtl/fcd_req_regs.sv
module fcd_req_regs
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W = 17,
    localparam int SECT_W = ADDR_W - SECT_SHIFT,
    localparam int BLK_W  = ADDR_W - BLK_SHIFT
) (
    input  logic              clk,
    input  logic              rst,
    input  cmd_t              cmd_fire,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    output logic              prog_req,
    output logic [ADDR_W-1:0] prog_addr,
    output logic [7:0]        prog_data,
    output logic              chip_erase_req,
    output logic              sect_erase_req,
    output logic              blk_erase_req,
    output logic [SECT_W-1:0] erase_sector,
    output logic [BLK_W-1:0]  erase_block,
    output logic              id_enter_req,
    output logic              id_exit_req,
    output logic              id_mode
);
    always_ff @(posedge clk) begin
        if (rst) begin
            prog_req       <= 1'b0;
            chip_erase_req <= 1'b0;
            sect_erase_req <= 1'b0;
            blk_erase_req  <= 1'b0;
            id_enter_req   <= 1'b0;
            id_exit_req    <= 1'b0;
            id_mode        <= 1'b0;
            prog_addr      <= '0;
            prog_data      <= '0;
            erase_sector   <= '0;
            erase_block    <= '0;
        end else begin
            prog_req       <= (cmd_fire == CMD_PROG);
            chip_erase_req <= (cmd_fire == CMD_CHIP);
            sect_erase_req <= (cmd_fire == CMD_SECT);
            blk_erase_req  <= (cmd_fire == CMD_BLK);
            id_enter_req   <= (cmd_fire == CMD_ID_ON);
            id_exit_req    <= (cmd_fire == CMD_ID_OFF);
            if (cmd_fire == CMD_PROG) begin
                prog_addr <= wr_addr;
                prog_data <= wr_data;
            end
            if (cmd_fire == CMD_SECT) erase_sector <= wr_addr[ADDR_W-1:SECT_SHIFT];
            if (cmd_fire == CMD_BLK)  erase_block  <= wr_addr[ADDR_W-1:BLK_SHIFT];
            if (cmd_fire == CMD_ID_ON)       id_mode <= 1'b1;
            else if (cmd_fire == CMD_ID_OFF) id_mode <= 1'b0;
        end
    end

    // R12: never two requests in one cycle
    assert_single_req_R12: assert property (@(posedge clk) disable iff (rst)
        $onehot0({prog_req, chip_erase_req, sect_erase_req, blk_erase_req,
                  id_enter_req, id_exit_req}));
endmodule

// File: rtl/fcd_id_read.sv
module fcd_id_read #(
    parameter logic [7:0] MFR_CODE = 8'h9D,
    parameter logic [7:0] DEV_CODE = 8'h1C
) (
    input  logic       id_mode,
    input  logic       id_rd_lsb,
    output logic [7:0] id_rd_data
);
    always_comb begin
        if (!id_mode)       id_rd_data = 8'h00;
        else if (id_rd_lsb) id_rd_data = DEV_CODE;
        else                id_rd_data = MFR_CODE;
    end
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
    import flash_cmd_pkg::*;
#(
    parameter int         ADDR_W   = 17,
    parameter logic [7:0] MFR_CODE = 8'h9D,
    parameter logic [7:0] DEV_CODE = 8'h1C,
    localparam int SECT_W = ADDR_W - SECT_SHIFT,
    localparam int BLK_W  = ADDR_W - BLK_SHIFT
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_valid,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              busy_i,
    input  logic              id_rd_lsb,
    output logic              prog_req,
    output logic [ADDR_W-1:0] prog_addr,
    output logic [7:0]        prog_data,
    output logic              chip_erase_req,
    output logic              sect_erase_req,
    output logic              blk_erase_req,
    output logic [SECT_W-1:0] erase_sector,
    output logic [BLK_W-1:0]  erase_block,
    output logic              id_enter_req,
    output logic              id_exit_req,
    output logic              id_mode,
    output logic [7:0]        id_rd_data
);
    cyc_class_t cls;
    cmd_t       cmd_fire;

    fcd_classify u_classify (
        .lo_addr (wr_addr[CMP_BITS-1:0]),
        .data    (wr_data),
        .cls     (cls)
    );

    fcd_seq_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .wr_valid (wr_valid),
        .busy_i   (busy_i),
        .cls      (cls),
        .cmd_fire (cmd_fire)
    );

    fcd_req_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk            (clk),
        .rst            (rst),
        .cmd_fire       (cmd_fire),
        .wr_addr        (wr_addr),
        .wr_data        (wr_data),
        .prog_req       (prog_req),
        .prog_addr      (prog_addr),
        .prog_data      (prog_data),
        .chip_erase_req (chip_erase_req),
        .sect_erase_req (sect_erase_req),
        .blk_erase_req  (blk_erase_req),
        .erase_sector   (erase_sector),
        .erase_block    (erase_block),
        .id_enter_req   (id_enter_req),
        .id_exit_req    (id_exit_req),
        .id_mode        (id_mode)
    );

    fcd_id_read #(.MFR_CODE(MFR_CODE), .DEV_CODE(DEV_CODE)) u_id (
        .id_mode    (id_mode),
        .id_rd_lsb  (id_rd_lsb),
        .id_rd_data (id_rd_data)
    );

    // R11: nothing is requested for a write seen under busy
    assert_busy_discard_R11: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && busy_i) |=> !(prog_req || chip_erase_req || sect_erase_req ||
                                   blk_erase_req || id_enter_req || id_exit_req));

    // R6: entry pulse coincides with ID mode on
    assert_id_enter_R6: assert property (@(posedge clk) disable iff (rst)
        id_enter_req |-> id_mode);

    // R7: exit pulse coincides with ID mode off
    assert_id_exit_R7: assert property (@(posedge clk) disable iff (rst)
        id_exit_req |-> !id_mode);

    // R12: program request lasts one cycle
    assert_prog_pulse_R12: assert property (@(posedge clk) disable iff (rst)
        prog_req |=> !prog_req);

    // R4: sector erase only follows a 30h data cycle
    assert_sect_code_R4: assert property (@(posedge clk) disable iff (rst)
        sect_erase_req |-> ($past(wr_data) == DAT_SECT));

    // R3: chip erase only follows a cycle at 555h in the low bits
    assert_chip_addr_R3: assert property (@(posedge clk) disable iff (rst)
        chip_erase_req |-> ($past(wr_addr[CMP_BITS-1:0]) == ADR_KEY_A));
endmodule

// File: tb/flash_cmd_decoder_tb.sv
module flash_cmd_decoder_tb;
    localparam int AW = 17;
    localparam logic [7:0] MFR = 8'h9D;
    localparam logic [7:0] DEV = 8'h1C;

    // vector: {busy, addr[16:0], data[7:0], exp_cmd[2:0], exp_id}
    // exp_cmd: 0 none, 1 prog, 2 sector, 3 block, 4 chip, 5 id on, 6 id off
    localparam int NV = 51;
    localparam logic [29:0] VEC [NV] = '{
        // R2 program
        {1'b0, 17'h00555, 8'hAA, 3'd0, 1'b0},
        {1'b0, 17'h002AA, 8'h55, 3'd0, 1'b0},
        {1'b0, 17'h00555, 8'hA0, 3'd0, 1'b0},
        {1'b0, 17'h12345, 8'h3C, 3'd1, 1'b0},
        // R3 chip erase
        {1'b0, 17'h00555, 8'hAA, 3'd0, 1'b0},
        {1'b0, 17'h002AA, 8'h55, 3'd0, 1'b0},
        {1'b0, 17'h00555, 8'h80, 3'd0, 1'b0},
        {1'b0, 17'h00555, 8'hAA, 3'd0, 1'b0},
        {1'b0, 17'h002AA, 8'h55, 3'd0, 1'b0},
        {1'b0, 17'h00555, 8'h10, 3'd4, 1'b0},
        // R4 sector erase
        {1'b0, 17'h00555, 8'hAA, 3'd0, 1'b0},
        {1'b0, 17'h002AA, 8'h55, 3'd0, 1'b0},
        {1'b0, 17'h00555, 8'h80, 3'd0, 1'b0},
        {1'b0, 17'h00555, 8'hAA, 3'd0, 1'b0},
        {1'b0, 17'h002AA, 8'h55, 3'd0, 1'b0},
        {1'b0, 17'h07123, 8'h30, 3'd2, 1'b0},
        // R5 block erase
        {1'b0, 17'h00555, 8'hAA, 3'd0, 1'b0},
        {1'b0, 17'h002AA, 8'h55, 3'd0, 1'b0},
        {1'b0, 17'h00555, 8'h80, 3'd0, 1'b0},
        {1'b0, 17'h00555, 8'hAA, 3'd0, 1'b0},
        {1'b0, 17'h002AA, 8'h55, 3'd0, 1'b0},
        {1'b0, 17'h1F00F, 8'h50, 3'd3, 1'b0},
        // R6 entry, R7 three-cycle exit
        {1'b0, 17'h00555, 8'hAA, 3'd0, 1'b0},
        {1'b0, 17'h002AA, 8'h55, 3'd0, 1'b0},
        {1'b0, 17'h00555, 8'h90, 3'd5, 1'b1},
        {1'b0, 17'h00555, 8'hAA, 3'd0, 1'b1},
        {1'b0, 17'h002AA, 8'h55, 3'd0, 1'b1},
        {1'b0, 17'h00555, 8'hF0, 3'd6, 1'b0},
        // R7 single-cycle exit at any address
        {1'b0, 17'h00555, 8'hAA, 3'd0, 1'b0},
        {1'b0, 17'h002AA, 8'h55, 3'd0, 1'b0},
        {1'b0, 17'h00555, 8'h90, 3'd5, 1'b1},
        {1'b0, 17'h1ABCD, 8'hF0, 3'd6, 1'b0},
        // R9 upper address bits ignored
        {1'b0, 17'h1F555, 8'hAA, 3'd0, 1'b0},
        {1'b0, 17'h0A2AA, 8'h55, 3'd0, 1'b0},
        {1'b0, 17'h13555, 8'hA0, 3'd0, 1'b0},
        {1'b0, 17'h00042, 8'h77, 3'd1, 1'b0},
        // R10 wrong address in cycle 2, then the rest of a program
        {1'b0, 17'h00555, 8'hAA, 3'd0, 1'b0},
        {1'b0, 17'h002AB, 8'h55, 3'd0, 1'b0},
        {1'b0, 17'h00555, 8'hA0, 3'd0, 1'b0},
        {1'b0, 17'h00011, 8'h11, 3'd0, 1'b0},
        // R10 chip-erase code at a wrong address
        {1'b0, 17'h00555, 8'hAA, 3'd0, 1'b0},
        {1'b0, 17'h002AA, 8'h55, 3'd0, 1'b0},
        {1'b0, 17'h00555, 8'h80, 3'd0, 1'b0},
        {1'b0, 17'h00555, 8'hAA, 3'd0, 1'b0},
        {1'b0, 17'h002AA, 8'h55, 3'd0, 1'b0},
        {1'b0, 17'h00556, 8'h10, 3'd0, 1'b0},
        // R11 busy on the data cycle, then a stray write from idle
        {1'b0, 17'h00555, 8'hAA, 3'd0, 1'b0},
        {1'b0, 17'h002AA, 8'h55, 3'd0, 1'b0},
        {1'b0, 17'h00555, 8'hA0, 3'd0, 1'b0},
        {1'b1, 17'h00100, 8'h12, 3'd0, 1'b0},
        {1'b0, 17'h00100, 8'h12, 3'd0, 1'b0}
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_valid = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [7:0]    wr_data = '0;
    logic          busy_i = 1'b0;
    logic          id_rd_lsb = 1'b0;
    logic          prog_req, chip_erase_req, sect_erase_req, blk_erase_req;
    logic          id_enter_req, id_exit_req, id_mode;
    logic [AW-1:0] prog_addr;
    logic [7:0]    prog_data, id_rd_data;
    logic [AW-13:0] erase_sector;
    logic [AW-17:0] erase_block;

    int tests = 0;
    int fails = 0;
    int cyc   = 0;
    bit done  = 0;

    always #5 clk = ~clk;

    flash_cmd_decoder #(.ADDR_W(AW), .MFR_CODE(MFR), .DEV_CODE(DEV)) u_dut (
        .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_addr(wr_addr),
        .wr_data(wr_data), .busy_i(busy_i), .id_rd_lsb(id_rd_lsb),
        .prog_req(prog_req), .prog_addr(prog_addr), .prog_data(prog_data),
        .chip_erase_req(chip_erase_req), .sect_erase_req(sect_erase_req),
        .blk_erase_req(blk_erase_req), .erase_sector(erase_sector),
        .erase_block(erase_block), .id_enter_req(id_enter_req),
        .id_exit_req(id_exit_req), .id_mode(id_mode), .id_rd_data(id_rd_data)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [2:0] obs_cmd();
        logic [5:0] v;
        v = {id_exit_req, id_enter_req, chip_erase_req, blk_erase_req, sect_erase_req, prog_req};
        case (v)
            6'b000000: return 3'd0;
            6'b000001: return 3'd1;
            6'b000010: return 3'd2;
            6'b000100: return 3'd3;
            6'b001000: return 3'd4;
            6'b010000: return 3'd5;
            6'b100000: return 3'd6;
            default:   return 3'd7;
        endcase
    endfunction

    function automatic string tag_of(input logic [2:0] c, input logic b);
        case (c)
            3'd1: return "R2";
            3'd2: return "R4";
            3'd3: return "R5";
            3'd4: return "R3";
            3'd5: return "R6";
            3'd6: return "R7";
            default: return b ? "R11" : "R10";
        endcase
    endfunction

    // one write cycle; returns at the negedge after the capturing edge
    task automatic bus_write(input logic b, input logic [AW-1:0] a, input logic [7:0] d);
        @(negedge clk);
        busy_i = b; wr_valid = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_valid = 1'b0; busy_i = 1'b0;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !done) begin
            done = 1;
            fails++;
            tests++;
            $display("FAIL watchdog actual=%0d expected=<20000", cyc);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        check("R1 requests", {26'd0, obs_cmd()}, 32'd0);
        check("R1 id_mode", {31'd0, id_mode}, 32'd0);

        for (int i = 0; i < NV; i++) begin
            logic          vb;
            logic [AW-1:0] va;
            logic [7:0]    vd;
            logic [2:0]    vc;
            logic          vi;
            {vb, va, vd, vc, vi} = VEC[i];
            bus_write(vb, va, vd);
            check(tag_of(vc, vb), {29'd0, obs_cmd()}, {29'd0, vc});
            check(vc == 3'd6 ? "R7" : "R6", {31'd0, id_mode}, {31'd0, vi});
            if (vc == 3'd1) begin
                check("R2 addr", {15'd0, prog_addr}, {15'd0, va});
                check("R2 data", {24'd0, prog_data}, {24'd0, vd});
            end
            if (vc == 3'd2) check("R4 index", {27'd0, erase_sector}, {27'd0, va[AW-1:12]});
            if (vc == 3'd3) check("R5 index", {31'd0, erase_block}, {31'd0, va[AW-1:16]});
            if (vc != 3'd0) begin
                @(negedge clk);
                check("R12 pulse", {29'd0, obs_cmd()}, 32'd0);
            end
        end

        // R8 identification reads, R11 busy exit ignored
        bus_write(1'b0, 17'h00555, 8'hAA);
        bus_write(1'b0, 17'h002AA, 8'h55);
        bus_write(1'b0, 17'h00555, 8'h90);
        id_rd_lsb = 1'b0; #1;
        check("R8 mfr", {24'd0, id_rd_data}, {24'd0, MFR});
        id_rd_lsb = 1'b1; #1;
        check("R8 dev", {24'd0, id_rd_data}, {24'd0, DEV});
        bus_write(1'b1, 17'h00000, 8'hF0);
        check("R11 exit under busy", {29'd0, obs_cmd()}, 32'd0);
        check("R11 id kept", {31'd0, id_mode}, 32'd1);

        // R1 reset clears ID mode
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        check("R1 id cleared", {31'd0, id_mode}, 32'd0);
        check("R8 outside id", {24'd0, id_rd_data}, 32'd0);

        // R1 reset drops a half-entered sequence
        bus_write(1'b0, 17'h00555, 8'hAA);
        bus_write(1'b0, 17'h002AA, 8'h55);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        bus_write(1'b0, 17'h00555, 8'h90);
        check("R1 sequence dropped", {31'd0, id_mode}, 32'd0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule